// File: doc/BRIEF.md
# Asynchronous DRAM Page-Mode Controller

This block sits between a host and one asynchronous DRAM device. It turns single requests into RAS/CAS strobe sequences, with the row and column sharing a multiplexed address bus. The host offers a request with a row, a column, a direction and write data. The controller grants the request when it can start it. For a read, the controller later returns the word with a one-cycle valid pulse.

After an access the controller leaves the row open. A later request to the same row skips activation and repeats only the column phase. A request to another row first closes the page and waits out the precharge time. The `edo_mode` input selects extended-data-out behaviour: the output enable stays asserted after a read, so the DRAM keeps the last word driven while the next column cycle starts. An internal interval counter schedules one RAS-only refresh per period, walking the rows in order. A due refresh closes any open page and outranks host traffic. The activation delay, CAS pulse width and precharge time are parameters counted in clock cycles.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are 1, `rd_valid` is 0 and `req_ready` is 0.
- R2: Opening a row drives the row address on `dram_addr` for at least one cycle with RAS high before RAS falls. CAS falls no sooner than `T_RCD` cycles after RAS fell, with the column address on `dram_addr`.
- R3: A read keeps WE high and OE low while CAS is low. It then pulses `rd_valid` for exactly one cycle, with `rd_data` equal to the word stored at that row and column.
- R4: A write drives WE low from the cycle before CAS falls until CAS rises, with the word on `dram_dq_out` and `dram_dq_oe` set. OE stays high whenever WE is low.
- R5: Every CAS low pulse lasts exactly `T_CAS` cycles.
- R6: A request whose row equals the open row is served without RAS rising or falling.
- R7: A request to a different row raises RAS first. RAS then stays high for at least `T_RP` cycles, and for exactly `T_RP`+2 cycles when the page is closed for that request.
- R8: With `edo_mode` 1, OE stays low after a read while CAS is high and the page stays open. With `edo_mode` 0, OE is high whenever CAS is high.
- R9: A RAS-only refresh (RAS low and back high with no CAS fall) occurs once every `REF_INTERVAL` cycles. Refreshed rows count up by one and wrap from the last row to row 0.
- R10: While a refresh is due, `req_ready` stays low. Refreshes keep their rate under continuous host traffic.
- R11: CAS falls only while RAS is low, and RAS rises only while CAS is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| edo_mode | input | 1 | 1 keeps OE asserted after reads (extended data out) |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 write, 0 read |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Grant; the request is taken on a clock edge where both valid and ready are 1 |
| rd_valid | output | 1 | One-cycle pulse marking returned read data |
| rd_data | output | DATA_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | DATA_W | Data from the DRAM |

## Verification
The assertions assume the host holds `req_valid` and all request fields steady from the cycle it raises them until the edge that grants the request. They also assume the parameters are all at least 1. The strobe checks further rely on the DRAM presenting read data no later than the last CAS-low cycle. The bench's host task changes request fields only at falling edges and releases them one cycle after the grant. It toggles `edo_mode` only between transfers. Its DRAM model returns data from the first CAS-low cycle on.

// File: rtl/dram_pctl_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the DRAM page controller.
// Assumes: the precharge state is encoded as zero so that strobes read
// inactive before the first clock edge.
package dram_pctl_pkg;

    typedef enum logic [2:0] {
        ST_PRECH     = 3'd0,  // RAS high, waiting out precharge
        ST_IDLE      = 3'd1,  // page closed, ready for a new row
        ST_ROW_ADDR  = 3'd2,  // row address set up, RAS still high
        ST_ACTIVE    = 3'd3,  // RAS low, RAS-to-CAS (or refresh) wait
        ST_COL_ADDR  = 3'd4,  // column address set up, CAS high
        ST_STROBE    = 3'd5,  // CAS low pulse
        ST_PAGE_OPEN = 3'd6   // RAS low, CAS high, row kept open
    } seq_state_t;

    // Larger of two cycle counts, used for counter sizing.
    function automatic int unsigned cyc_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_pctl_delay.sv
`timescale 1ns/1ps
// Down-counter shared by every timed phase of the sequencer.
// Assumes: a load value of N-1 keeps the caller in its state for N cycles.
module dram_pctl_delay #(
    parameter int CW      = 4,
    parameter int RST_VAL = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= CW'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/dram_pctl_refresh.sv
`timescale 1ns/1ps
// Refresh scheduler: raises a pending flag once per INTERVAL cycles and
// keeps the row to refresh next.
// Assumes: the sequencer acknowledges within one interval; a tick that
// lands while a refresh is still pending merges with it.
module dram_pctl_refresh #(
    parameter int INTERVAL = 780,
    parameter int ROW_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             pending,
    output logic [ROW_W-1:0] row
);

    localparam int IW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    logic [IW-1:0] tick_cnt;
    logic          tick;

    assign tick = (tick_cnt == IW'(INTERVAL - 1));

    // Free-running interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_cnt <= '0;
        else if (tick)
            tick_cnt <= '0;
        else
            tick_cnt <= tick_cnt + 1'b1;
    end

    // Pending flag: set on a tick, cleared on acknowledge (tick wins).
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (tick)
            pending <= 1'b1;
        else if (ack)
            pending <= 1'b0;
    end

    // Row pointer advances after each refresh is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)
            row <= '0;
        else if (ack)
            row <= row + 1'b1;
    end

endmodule

// File: rtl/dram_pctl_seq.sv
`timescale 1ns/1ps
// Strobe sequencer: walks activation, column, page-open and precharge
// phases, decides page hits and misses, and inserts refreshes.
// Assumes: host fields are stable while req_valid is high and until the
// grant; DRAM read data is valid by the last CAS-low cycle.
module dram_pctl_seq
    import dram_pctl_pkg::*;
#(
    parameter int ROW_W     = 10,
    parameter int COL_W     = 9,
    parameter int DATA_W    = 16,
    parameter int AW        = 10,
    parameter int CW        = 4,
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 2,
    parameter int T_RP      = 2,
    parameter int T_REF_ACT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edo_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ref_pending,
    input  logic [ROW_W-1:0]  ref_row,
    output logic              ref_ack,
    output logic              cnt_load,
    output logic [CW-1:0]     cnt_val,
    input  logic              cnt_expired,
    output logic [AW-1:0]     dram_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);

    seq_state_t        state, nxt;
    logic              op_write, op_refresh, oe_hold, rdv_q;
    logic [ROW_W-1:0]  open_row;
    logic [COL_W-1:0]  col_q;
    logic [AW-1:0]     addr_q;
    logic [DATA_W-1:0] wdata_q, rd_q;
    logic              go_open, go_hit, ref_start, page_close, row_hit;

    assign row_hit = (req_row == open_row);

    // Next state, grant, refresh acknowledge and counter loads.
    always_comb begin
        nxt        = state;
        req_ready  = 1'b0;
        ref_ack    = 1'b0;
        cnt_load   = 1'b0;
        cnt_val    = '0;
        go_open    = 1'b0;
        go_hit     = 1'b0;
        ref_start  = 1'b0;
        page_close = 1'b0;
        case (state)
            ST_PRECH: begin
                if (cnt_expired) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (ref_pending) begin
                    ref_ack   = 1'b1;
                    ref_start = 1'b1;
                    nxt       = ST_ROW_ADDR;
                end else begin
                    req_ready = 1'b1;
                    if (req_valid) begin
                        go_open = 1'b1;
                        nxt     = ST_ROW_ADDR;
                    end
                end
            end
            ST_ROW_ADDR: begin
                nxt      = ST_ACTIVE;
                cnt_load = 1'b1;
                cnt_val  = op_refresh ? CW'(T_REF_ACT - 1) : CW'(T_RCD - 1);
            end
            ST_ACTIVE: begin
                if (cnt_expired) begin
                    if (op_refresh) begin
                        nxt      = ST_PRECH;
                        cnt_load = 1'b1;
                        cnt_val  = CW'(T_RP - 1);
                    end else begin
                        nxt = ST_COL_ADDR;
                    end
                end
            end
            ST_COL_ADDR: begin
                nxt      = ST_STROBE;
                cnt_load = 1'b1;
                cnt_val  = CW'(T_CAS - 1);
            end
            ST_STROBE: begin
                if (cnt_expired) nxt = ST_PAGE_OPEN;
            end
            ST_PAGE_OPEN: begin
                if (ref_pending) begin
                    page_close = 1'b1;
                end else begin
                    req_ready = row_hit;
                    if (req_valid) begin
                        if (row_hit) begin
                            go_hit = 1'b1;
                            nxt    = ST_COL_ADDR;
                        end else begin
                            page_close = 1'b1;
                        end
                    end
                end
                if (page_close) begin
                    nxt      = ST_PRECH;
                    cnt_load = 1'b1;
                    cnt_val  = CW'(T_RP - 1);
                end
            end
            default: nxt = ST_PRECH;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_PRECH;
        else
            state <= nxt;
    end

    // Operation, address and write data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_write   <= 1'b0;
            op_refresh <= 1'b0;
            open_row   <= '0;
            col_q      <= '0;
            addr_q     <= '0;
            wdata_q    <= '0;
        end else begin
            if (go_open) begin
                op_write   <= req_write;
                op_refresh <= 1'b0;
                open_row   <= req_row;
                col_q      <= req_col;
                addr_q     <= AW'(req_row);
                wdata_q    <= req_wdata;
            end
            if (ref_start) begin
                op_write   <= 1'b0;
                op_refresh <= 1'b1;
                addr_q     <= AW'(ref_row);
            end
            if (go_hit) begin
                op_write <= req_write;
                addr_q   <= AW'(req_col);
                wdata_q  <= req_wdata;
            end
            if (state == ST_ACTIVE && cnt_expired && !op_refresh)
                addr_q <= AW'(col_q);
        end
    end

    // Read capture, valid pulse and extended-data-out hold flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= '0;
            rdv_q   <= 1'b0;
            oe_hold <= 1'b0;
        end else begin
            rdv_q <= 1'b0;
            if (state == ST_STROBE && cnt_expired) begin
                if (!op_write) begin
                    rd_q    <= dq_in;
                    rdv_q   <= 1'b1;
                    oe_hold <= edo_mode;
                end else begin
                    oe_hold <= 1'b0;
                end
            end
            if (go_hit && req_write) oe_hold <= 1'b0;
            if (page_close)          oe_hold <= 1'b0;
        end
    end

    // Strobe decode from the state register.
    always_comb begin
        ras_n = !(state inside {ST_ACTIVE, ST_COL_ADDR, ST_STROBE, ST_PAGE_OPEN});
        cas_n = (state != ST_STROBE);
        we_n  = !(op_write && (state inside {ST_COL_ADDR, ST_STROBE}));
        dq_oe = op_write && (state inside {ST_COL_ADDR, ST_STROBE});
        if (state == ST_STROBE && !op_write)
            oe_n = 1'b0;
        else if ((state inside {ST_COL_ADDR, ST_PAGE_OPEN}) && oe_hold)
            oe_n = 1'b0;
        else
            oe_n = 1'b1;
    end

    assign dram_addr = addr_q;
    assign dq_out    = wdata_q;
    assign rd_valid  = rdv_q;
    assign rd_data   = rd_q;

endmodule

// File: rtl/dram_page_ctrl.sv
`timescale 1ns/1ps
// Asynchronous DRAM page-mode controller top: sequencer, shared phase
// counter and refresh scheduler.
// Assumes: all cycle-count parameters are at least 1, REF_INTERVAL is well
// above one full page-miss access, ROW_W and COL_W fit dram_addr.
module dram_page_ctrl #(
    parameter int ROW_W        = 10,
    parameter int COL_W        = 9,
    parameter int DATA_W       = 16,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_RP         = 2,
    parameter int REF_INTERVAL = 780
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  edo_mode,
    input  logic                                  req_valid,
    input  logic                                  req_write,
    input  logic [ROW_W-1:0]                      req_row,
    input  logic [COL_W-1:0]                      req_col,
    input  logic [DATA_W-1:0]                     req_wdata,
    output logic                                  req_ready,
    output logic                                  rd_valid,
    output logic [DATA_W-1:0]                     rd_data,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic                                  dram_ras_n,
    output logic                                  dram_cas_n,
    output logic                                  dram_we_n,
    output logic                                  dram_oe_n,
    output logic [DATA_W-1:0]                     dram_dq_out,
    output logic                                  dram_dq_oe,
    input  logic [DATA_W-1:0]                     dram_dq_in
);

    import dram_pctl_pkg::*;

    localparam int AW        = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int T_REF_ACT = T_RCD + T_CAS + 1;
    localparam int MAXT      = int'(cyc_max(cyc_max(T_RCD, T_CAS), cyc_max(T_RP, T_REF_ACT)));
    localparam int CW        = $clog2(MAXT + 1);

    logic             ref_pending, ref_ack;
    logic [ROW_W-1:0] ref_row;
    logic             cnt_load, cnt_expired;
    logic [CW-1:0]    cnt_val;

    dram_pctl_refresh #(
        .INTERVAL (REF_INTERVAL),
        .ROW_W    (ROW_W)
    ) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pending),
        .row     (ref_row)
    );

    dram_pctl_delay #(
        .CW      (CW),
        .RST_VAL (T_RP - 1)
    ) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .expired  (cnt_expired)
    );

    dram_pctl_seq #(
        .ROW_W     (ROW_W),
        .COL_W     (COL_W),
        .DATA_W    (DATA_W),
        .AW        (AW),
        .CW        (CW),
        .T_RCD     (T_RCD),
        .T_CAS     (T_CAS),
        .T_RP      (T_RP),
        .T_REF_ACT (T_REF_ACT)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .edo_mode    (edo_mode),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_row     (req_row),
        .req_col     (req_col),
        .req_wdata   (req_wdata),
        .req_ready   (req_ready),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .ref_pending (ref_pending),
        .ref_row     (ref_row),
        .ref_ack     (ref_ack),
        .cnt_load    (cnt_load),
        .cnt_val     (cnt_val),
        .cnt_expired (cnt_expired),
        .dram_addr   (dram_addr),
        .ras_n       (dram_ras_n),
        .cas_n       (dram_cas_n),
        .we_n        (dram_we_n),
        .oe_n        (dram_oe_n),
        .dq_out      (dram_dq_out),
        .dq_oe       (dram_dq_oe),
        .dq_in       (dram_dq_in)
    );

endmodule

// File: rtl/dram_page_ctrl_checker.sv
`timescale 1ns/1ps
// Protocol checker for the DRAM page controller, attached by bind.
// Assumes: reset is held low from time zero for at least one clock edge.
module dram_page_ctrl_checker #(
    parameter int T_CAS = 2,
    parameter int T_RP  = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic req_ready,
    input logic ref_pend,
    input logic rd_valid
);

    localparam int LW = $clog2(T_CAS + 2);
    localparam int HW = $clog2(T_RP + 2);

    logic [LW-1:0] lo_cnt;
    logic [HW-1:0] hi_cnt;

    // Length of the current CAS-low run.
    always_ff @(posedge clk) begin
        if (!rst_n || cas_n) lo_cnt <= '0;
        else                 lo_cnt <= lo_cnt + 1'b1;
    end

    // Length of the current RAS-high run, saturating at T_RP.
    always_ff @(posedge clk) begin
        if (!rst_n || !ras_n)              hi_cnt <= '0;
        else if (hi_cnt < HW'(T_RP))       hi_cnt <= hi_cnt + 1'b1;
    end

    p_cas_under_ras_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> !ras_n);
    p_ras_rise_cas_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> cas_n);
    p_we_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> $stable(we_n));
    p_write_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);
    p_cas_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> (lo_cnt == LW'(T_CAS)));
    p_precharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt >= HW'(T_RP)));
    p_refresh_blocks_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pend |-> !req_ready);
    p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

bind dram_page_ctrl dram_page_ctrl_checker #(
    .T_CAS (T_CAS),
    .T_RP  (T_RP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .req_ready (req_ready),
    .ref_pend  (ref_pending),
    .rd_valid  (rd_valid)
);

// File: tb/tb_dram_page_ctrl.sv
`timescale 1ns/1ps
// Bench: host driver, behavioural DRAM model on the strobes, protocol
// monitors and a scoreboard.
module tb_dram_page_ctrl;

    localparam int CLK_P   = 10;
    localparam int ROW_W   = 4;
    localparam int COL_W   = 5;
    localparam int DATA_W  = 16;
    localparam int T_RCD   = 2;
    localparam int T_CAS   = 2;
    localparam int T_RP    = 3;
    localparam int REF_INT = 300;
    localparam int AW      = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int NW      = 1 << (ROW_W + COL_W);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic edo_mode = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, rd_valid;
    logic [DATA_W-1:0] rd_data, dram_dq_out, dram_dq_in;
    logic [AW-1:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;

    always #(CLK_P/2) clk = ~clk;

    dram_page_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .REF_INTERVAL(REF_INT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .edo_mode(edo_mode),
        .req_valid(req_valid), .req_write(req_write), .req_row(req_row),
        .req_col(req_col), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    function automatic logic [DATA_W-1:0] init_word(input int i);
        return DATA_W'(i * 40503 ^ 32'h3c5a);
    endfunction

    // ---------------- DRAM model and monitors (negedge sampling) ----------
    logic [DATA_W-1:0] mem [NW];
    logic [DATA_W-1:0] sb  [NW];
    logic [ROW_W-1:0] row_l = '0, last_ref = '0;
    logic [COL_W-1:0] col_l = '0;
    logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1, prev_rdv = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic cas_act = 1'b0, hold_v = 1'b0, saw_cas = 1'b0, ref_seen = 1'b0;
    logic [DATA_W-1:0] hold_d = '0;
    int since_ras = 0, hi_run = 0, last_hi = 0, lo_run = 0;
    int act_cnt = 0, ref_cnt = 0, ref_wraps = 0, edo_gap = 0;
    int v_rcd = 0, v_row = 0, v_rp = 0, v_order = 0, v_cas = 0, v_we = 0;
    int v_oe = 0, v_wdrv = 0, v_refrow = 0, v_rdv = 0;

    wire [ROW_W+COL_W-1:0] cur_idx = {row_l, col_l};

    assign dram_dq_in = (!dram_cas_n && !dram_oe_n && cas_act) ? mem[cur_idx] :
                        (hold_v && !dram_oe_n) ? hold_d : 16'hDEAD;

    always @(negedge clk) begin
        if (rst_n) begin
            if (dram_ras_n) hi_run <= hi_run + 1;
            if (prev_ras && !dram_ras_n) begin
                row_l     <= dram_addr[ROW_W-1:0];
                act_cnt   <= act_cnt + 1;
                saw_cas   <= 1'b0;
                since_ras <= 1;
                last_hi   <= hi_run;
                hi_run    <= 0;
                if (hi_run < T_RP) v_rp <= v_rp + 1;
                if (prev_addr != dram_addr) v_row <= v_row + 1;
            end else if (!dram_ras_n) begin
                since_ras <= since_ras + 1;
            end
            if (!prev_ras && dram_ras_n) begin
                hold_v <= 1'b0;
                if (!dram_cas_n) v_order <= v_order + 1;
                if (!saw_cas) begin
                    ref_cnt <= ref_cnt + 1;
                    if (ref_seen && row_l != ROW_W'(last_ref + 1'b1)) v_refrow <= v_refrow + 1;
                    if (ref_seen && row_l == '0) ref_wraps <= ref_wraps + 1;
                    ref_seen <= 1'b1;
                    last_ref <= row_l;
                end
            end
            if (prev_cas && !dram_cas_n) begin
                if (dram_ras_n) v_order <= v_order + 1;
                if (!saw_cas && since_ras < T_RCD) v_rcd <= v_rcd + 1;
                saw_cas <= 1'b1;
                col_l   <= dram_addr[COL_W-1:0];
                cas_act <= 1'b1;
                hold_v  <= 1'b0;
                lo_run  <= 1;
                if (!dram_we_n) begin
                    mem[{row_l, dram_addr[COL_W-1:0]}] <= dram_dq_out;
                    if (!dram_dq_oe) v_wdrv <= v_wdrv + 1;
                end
            end else if (!dram_cas_n) begin
                lo_run <= lo_run + 1;
            end
            if (!prev_cas && dram_cas_n) begin
                cas_act <= 1'b0;
                if (lo_run != T_CAS) v_cas <= v_cas + 1;
                if (!dram_oe_n) begin hold_v <= 1'b1; hold_d <= mem[cur_idx]; end
            end
            if (dram_oe_n) hold_v <= 1'b0;
            if (!dram_cas_n && dram_we_n != prev_we) v_we <= v_we + 1;
            if (!dram_we_n && !dram_oe_n) v_oe <= v_oe + 1;
            if (dram_cas_n && !dram_ras_n && !dram_oe_n) edo_gap <= edo_gap + 1;
            if (rd_valid && prev_rdv) v_rdv <= v_rdv + 1;
        end
        prev_ras  <= dram_ras_n;
        prev_cas  <= dram_cas_n;
        prev_we   <= dram_we_n;
        prev_addr <= dram_addr;
        prev_rdv  <= rd_valid;
    end

    // ---------------- bench tasks ----------------------------------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input bit wr, input int row, input int col, input logic [DATA_W-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr;
        req_row = ROW_W'(row); req_col = COL_W'(col); req_wdata = d;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input int row, input int col, input logic [DATA_W-1:0] d);
        issue(1'b1, row, col, d);
        sb[{ROW_W'(row), COL_W'(col)}] = d;
    endtask

    // R3: returned word equals the scoreboard entry.
    task automatic do_read(input int row, input int col);
        logic [DATA_W-1:0] e;
        e = sb[{ROW_W'(row), COL_W'(col)}];
        issue(1'b0, row, col, '0);
        while (!rd_valid) @(negedge clk);
        chk(rd_data == e, "R3 read data", int'(rd_data), int'(e));
    endtask

    task automatic wait_refresh();
        int r0;
        r0 = ref_cnt;
        while (ref_cnt == r0) @(negedge clk);
    endtask

    // ---------------- watchdog --------------------------------------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R3 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- main sequence ---------------------------------------
    initial begin
        int a0, r0, c0, exp_ref, prev_row;
        void'($urandom(32'd2024));
        for (int i = 0; i < NW; i++) begin
            mem[i] = init_word(i);
            sb[i]  = init_word(i);
        end
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes in reset",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
        chk(!rd_valid && !req_ready, "R1 handshake in reset", {rd_valid, req_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !req_ready,
            "R1 after release", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, req_ready}, 5'h1E);

        // R4, R3, R6: write and read in one page, one activation
        wait_refresh();
        a0 = act_cnt;
        do_write(5, 3, 16'hA5C3);
        do_read(5, 3);
        do_read(5, 7);
        do_write(5, 8, 16'h0F1E);
        do_read(5, 8);
        chk(act_cnt - a0 == 1, "R6 page hits keep row open", act_cnt - a0, 1);

        // R7: page miss closes the row and precharges T_RP+2 cycles
        do_read(9, 0);
        chk(act_cnt - a0 == 2, "R7 miss reactivates", act_cnt - a0, 2);
        chk(last_hi == T_RP + 2, "R7 precharge length", last_hi, T_RP + 2);

        // R8: fast-page mode releases OE between column cycles
        wait_refresh();
        edo_gap = 0;
        do_read(9, 1);
        do_read(9, 2);
        repeat (3) @(negedge clk);
        chk(edo_gap == 0, "R8 OE released without EDO", edo_gap, 0);
        // R8: extended data out keeps OE low between column cycles
        edo_mode = 1'b1;
        do_read(9, 4);
        do_read(9, 5);
        repeat (3) @(negedge clk);
        chk(edo_gap > 0, "R8 OE held with EDO", edo_gap, 1);
        do_write(9, 6, 16'h7777);
        do_read(9, 6);
        edo_mode = 1'b0;

        // R9: idle refresh rate
        wait_refresh();
        r0 = ref_cnt;
        repeat (REF_INT * 10 - REF_INT / 2) @(negedge clk);
        chk(ref_cnt - r0 == 9, "R9 refresh count idle", ref_cnt - r0, 9);

        // Random traffic with page locality; R10 refresh under load
        r0 = ref_cnt;
        c0 = 0;
        prev_row = 0;
        fork
            begin : cyc_count
                forever begin @(negedge clk); c0++; end
            end
            begin
                for (int n = 0; n < 400; n++) begin
                    int row, col;
                    row = ($urandom % 10 < 7) ? prev_row : int'($urandom % 16);
                    col = int'($urandom % 32);
                    prev_row = row;
                    if (n % 50 == 0) edo_mode = $urandom % 2;
                    if ($urandom % 2) do_write(row, col, DATA_W'($urandom));
                    else              do_read(row, col);
                end
            end
        join_any
        disable fork;
        exp_ref = c0 / REF_INT;
        chk(ref_cnt - r0 + 1 >= exp_ref && ref_cnt - r0 <= exp_ref + 1,
            "R10 refresh rate under traffic", ref_cnt - r0, exp_ref);

        repeat (20) @(negedge clk);
        chk(v_rcd == 0 && v_row == 0, "R2 activation order", v_rcd + v_row, 0);
        chk(v_we == 0 && v_oe == 0 && v_wdrv == 0, "R4 write strobes", v_we + v_oe + v_wdrv, 0);
        chk(v_cas == 0, "R5 CAS width", v_cas, 0);
        chk(v_rp == 0, "R7 precharge minimum", v_rp, 0);
        chk(v_refrow == 0, "R9 refresh row order", v_refrow, 0);
        chk(ref_wraps >= 1, "R9 refresh row wrap", ref_wraps, 1);
        chk(v_order == 0, "R11 RAS/CAS ordering", v_order, 0);
        chk(v_rdv == 0, "R3 valid pulse width", v_rdv, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule